// File: doc/BRIEF.md
# Receive Buffer Ring Manager

This block sits between the byte output of a receive MAC and system memory. It keeps a pointer into a ring of two-word receive descriptors. When a frame starts, it reads the descriptor under the pointer and checks whether software still holds that buffer. If the buffer is free, the block packs the frame bytes into 32-bit words and writes them into the fixed-size buffer. When the buffer is full, or when the frame ends, it writes back a length and status word. It then sets the ownership bit in the descriptor, which hands the buffer to software, and steps the pointer to the next descriptor. A frame longer than one buffer continues in the next descriptor.

A descriptor whose ownership bit is already set is never written. That event raises a sticky flag and an interrupt, and it bumps a saturating resource-error counter. Any remaining bytes of the frame are discarded. Memory is reached through a simple request/acknowledge port: a request stays high until a one-cycle acknowledge arrives, and read data is valid with that acknowledge. Turning receive off only stops new frames from being accepted. The ring pointer stays where it is.

Top module: `rxd_ring_mgr`

## Requirements
- R1: While and after reset, and until a frame arrives, `mem_req`, `in_ready`, `irq` and `res_err_cnt` are all zero. The ring pointer is loaded from `base_addr` during reset.
- R2: When receive is on and a byte with `in_sof` is offered while idle, the block reads descriptor word 0 at the ring pointer. In word 0, bit 0 is ownership (1 = held by software), bit 1 is wrap, and bits [31:2] are the word-aligned buffer address. If bit 0 is clear, the buffer is used.
- R3: Frame bytes are packed little-endian: the byte at buffer offset k goes to lane k mod 4, bits [8(k mod 4)+7 : 8(k mod 4)]. Each word is written to buffer address + (k rounded down to a multiple of 4). In the last word of a buffer, lanes with no byte are written as zero.
- R4: A buffer holds BUF_BYTES bytes (128 by default). A longer frame continues in the next descriptor. For every buffer used, word 1 (pointer + 4) is written with the byte count in bits [12:0], bit 14 set on the first buffer of a frame, bit 15 set on the last, and all other bits zero.
- R5: After word 1, word 0 is rewritten with its read value and bit 0 set. The pointer then becomes `base_addr` if the wrap bit was set, and pointer + 8 otherwise.
- R6: A descriptor read with bit 0 set is not written. It sets `nobuf_flag`, and `irq` goes high with it. Both stay high until a cycle with `nobuf_clr` high, unless a new event happens in that same cycle.
- R7: Every not-available event adds one to `res_err_cnt`. At the all-ones value the counter stays put.
- R8: After a not-available event, whether at a frame start or in the middle of a frame, the block accepts and discards the rest of that frame through its end byte. The pointer stays on the owned descriptor, so the next frame retries it.
- R9: While `rx_en` is low in idle, `in_ready` and `mem_req` stay low. The pointer keeps its value, and once receive is on again the next frame goes to the descriptor after the last one used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_en | input | 1 | Receive enable; gates the start of new frames |
| base_addr | input | ADDR_W | Byte address of the first descriptor of the ring |
| in_valid | input | 1 | Byte on `in_data` is valid |
| in_data | input | 8 | Received frame byte |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_ready | output | 1 | Byte is taken at the clock edge when high with `in_valid` |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |
| nobuf_clr | input | 1 | Write-one-to-clear for the not-available flag |
| nobuf_flag | output | 1 | Sticky buffer-not-available status |
| irq | output | 1 | Interrupt, high while the status flag is set |
| res_err_cnt | output | CNT_W | Saturating count of not-available events |

## Verification
A byte-count register that slips shows up as a length field in descriptor word 1 that no longer matches the frame. It also moves packed data to the wrong lane or word, and the buffer contents reveal this in the same frame. A pointer that misses a step or ignores wrap sends the next descriptor write to an unexpected address, so the descriptor-write scoreboard reports it the next time a buffer is handed back. A wrong ownership decision leaves the not-available flag or counter out of line with the bench's model as soon as the frame ends. If the block stays in the discard state too long, the next frame is swallowed and its descriptor writes never appear.

// File: rtl/rxd_pkg.sv
// Shared definitions for the receive buffer ring manager: controller states
// and bit positions inside the two descriptor words.
package rxd_pkg;

    localparam int DATA_W   = 32;
    localparam int OWN_BIT  = 0;   // word 0: 1 = buffer held by software
    localparam int WRAP_BIT = 1;   // word 0: last descriptor of the ring
    localparam int LEN_W    = 13;  // word 1: byte count field width
    localparam int SOF_BIT  = 14;  // word 1: first buffer of the frame
    localparam int EOF_BIT  = 15;  // word 1: last buffer of the frame

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a frame start
        ST_FETCH,  // reading descriptor word 0
        ST_RECV,   // taking bytes into the word packer
        ST_WDATA,  // writing one packed data word
        ST_WLEN,   // writing descriptor word 1
        ST_WOWN,   // writing descriptor word 0 with ownership set
        ST_DROP    // discarding the rest of a frame
    } rx_state_e;

endpackage

// File: rtl/rxd_word_pack.sv
// Byte-to-word packer. It collects bytes little-endian into one 32-bit word.
// Assumes the controller loads one byte per cycle at the lane it selects and
// flushes the word once it has been written to memory, so unused lanes read
// as zero.
module rxd_word_pack
    import rxd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [1:0]        lane,
    input  logic [7:0]        byte_in,
    input  logic              flush,
    output logic [DATA_W-1:0] word
);

    // Place the byte in its lane, or clear the word after a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (flush) begin
            word <= '0;
        end else if (load) begin
            word[lane*8 +: 8] <= byte_in;
        end
    end

endmodule

// File: rtl/rxd_ring_ptr.sv
// Descriptor ring pointer. It loads the base address during reset and steps
// by one descriptor (8 bytes) or back to the base when told to advance.
// Assumes base_addr is 8-byte aligned and steady while reset is applied.
module rxd_ring_ptr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              advance,
    input  logic              wrap,
    output logic [ADDR_W-1:0] ptr
);

    localparam logic [ADDR_W-1:0] DESC_STEP = ADDR_W'(8);

    // Hold, step or wrap the pointer; nothing else moves it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= base_addr;
        end else if (advance) begin
            ptr <= wrap ? base_addr : ptr + DESC_STEP;
        end
    end

endmodule

// File: rtl/rxd_nobuf_stat.sv
// Buffer-not-available status. It keeps a sticky flag that is cleared by
// writing one, and a saturating event counter. Assumes evt is a one-cycle
// pulse for each event; a set in the same cycle as a clear wins.
module rxd_nobuf_stat #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    output logic             flag,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Sticky flag: set on event, cleared on a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // Event counter that stops at its maximum value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (evt && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R6: the flag only drops on a clear request
    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R7: a full counter never wraps
    a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX) |=> (cnt == CNT_MAX));

endmodule

// File: rtl/rxd_ring_mgr.sv
// Receive buffer ring manager, top level. It fetches a descriptor at each
// frame start and whenever a buffer fills, stores bytes into the buffer,
// writes back length/status and ownership, and flags owned descriptors.
// Assumes the memory port acknowledges each request with a one-cycle pulse,
// with read data valid in that cycle, and that the request stays high until
// then.
module rxd_ring_mgr
    import rxd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUF_BYTES = 128,
    parameter int CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              in_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              nobuf_clr,
    output logic              nobuf_flag,
    output logic              irq,
    output logic [CNT_W-1:0]  res_err_cnt
);

    localparam int              BC_W      = $clog2(BUF_BYTES) + 1;
    localparam logic [BC_W-1:0] BC_FULL   = BC_W'(BUF_BYTES);
    localparam logic [BC_W-1:0] BC_ALIGN  = ~BC_W'(3);
    localparam logic [ADDR_W-1:0] A_ALIGN = ~ADDR_W'(3);

    rx_state_e         state;
    logic [BC_W-1:0]   bcnt;      // bytes stored in the current buffer
    logic [BC_W-1:0]   wr_off;    // offset of the last byte taken
    logic [DATA_W-1:0] w0_q;      // descriptor word 0 as read
    logic              sof_q;     // current buffer starts the frame
    logic              eof_q;     // frame end byte has been taken

    logic              accept;
    logic              nobuf_evt;
    logic              ptr_adv;
    logic              flush;
    logic [ADDR_W-1:0] ptr;
    logic [DATA_W-1:0] packed_word;
    logic [ADDR_W-1:0] buf_base;

    assign in_ready  = (state == ST_RECV) || (state == ST_DROP);
    assign accept    = (state == ST_RECV) && in_valid;
    assign nobuf_evt = (state == ST_FETCH) && mem_ack && mem_rdata[OWN_BIT];
    assign ptr_adv   = (state == ST_WOWN) && mem_ack;
    assign flush     = (state == ST_WDATA) && mem_ack;
    assign buf_base  = w0_q[ADDR_W-1:0] & A_ALIGN;
    assign irq       = nobuf_flag;

    rxd_word_pack u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .lane    (bcnt[1:0]),
        .byte_in (in_data),
        .flush   (flush),
        .word    (packed_word)
    );

    rxd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_addr (base_addr),
        .advance   (ptr_adv),
        .wrap      (w0_q[WRAP_BIT]),
        .ptr       (ptr)
    );

    rxd_nobuf_stat #(.CNT_W(CNT_W)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (nobuf_evt),
        .clr   (nobuf_clr),
        .flag  (nobuf_flag),
        .cnt   (res_err_cnt)
    );

    // Frame and buffer sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            bcnt   <= '0;
            wr_off <= '0;
            w0_q   <= '0;
            sof_q  <= 1'b0;
            eof_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (rx_en && in_valid && in_sof) begin
                        state <= ST_FETCH;
                        sof_q <= 1'b1;
                        eof_q <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (mem_ack) begin
                        if (mem_rdata[OWN_BIT]) begin
                            state <= ST_DROP;
                        end else begin
                            w0_q  <= mem_rdata;
                            bcnt  <= '0;
                            state <= ST_RECV;
                        end
                    end
                end
                ST_RECV: begin
                    if (accept) begin
                        bcnt   <= bcnt + 1'b1;
                        wr_off <= bcnt;
                        eof_q  <= in_eof;
                        if (bcnt[1:0] == 2'd3 || in_eof) begin
                            state <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: begin
                    if (mem_ack) begin
                        state <= (eof_q || bcnt == BC_FULL) ? ST_WLEN : ST_RECV;
                    end
                end
                ST_WLEN: begin
                    if (mem_ack) begin
                        state <= ST_WOWN;
                    end
                end
                ST_WOWN: begin
                    if (mem_ack) begin
                        sof_q <= 1'b0;
                        state <= eof_q ? ST_IDLE : ST_FETCH;
                    end
                end
                ST_DROP: begin
                    if (in_valid && in_eof) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory request for the current state.
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr;
            end
            ST_WDATA: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = buf_base + ADDR_W'(wr_off & BC_ALIGN);
                mem_wdata = packed_word;
            end
            ST_WLEN: begin
                mem_req                = 1'b1;
                mem_we                 = 1'b1;
                mem_addr               = ptr + ADDR_W'(4);
                mem_wdata[LEN_W-1:0]   = LEN_W'(bcnt);
                mem_wdata[SOF_BIT]     = sof_q;
                mem_wdata[EOF_BIT]     = eof_q;
            end
            ST_WOWN: begin
                mem_req            = 1'b1;
                mem_we             = 1'b1;
                mem_addr           = ptr;
                mem_wdata          = w0_q;
                mem_wdata[OWN_BIT] = 1'b1;
            end
            default: ;
        endcase
    end

    // R6: the interrupt rises only after an owned descriptor was read
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(state == ST_FETCH && mem_ack && mem_rdata[OWN_BIT]));

    // R4: a buffer never takes more than its size
    a_r4_buf_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= BC_FULL);

    // R8: discarding a frame touches no memory
    a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DROP) |-> !mem_req);

    // R9: with receive off, an idle block stays idle and silent
    a_r9_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_en && state == ST_IDLE) |=> (state == ST_IDLE && !mem_req));

endmodule

// File: tb/sim_rxd_ring_mgr.sv
// Scoreboard bench: the frame driver predicts descriptor writes into a queue;
// the memory model pops and compares each descriptor write it serves.
module sim_rxd_ring_mgr;

    localparam int CLK_PERIOD = 10;
    localparam int NDESC      = 4;
    localparam int BUFB       = 128;
    localparam int CW         = 3;
    localparam int CMAX       = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_en = 1'b0;
    logic [31:0] base_addr = 32'h0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_ready;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        mem_ack = 1'b0;
    logic        nobuf_clr = 1'b0;
    logic        nobuf_flag, irq;
    logic [CW-1:0] res_err_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxd_ring_mgr #(.ADDR_W(32), .BUF_BYTES(BUFB), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .base_addr(base_addr),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .nobuf_clr(nobuf_clr), .nobuf_flag(nobuf_flag),
        .irq(irq), .res_err_cnt(res_err_cnt)
    );

    logic [31:0] mem [256];
    logic [63:0] exp_q [$];
    int n_chk = 0, n_fail = 0, sb_chk = 0, sb_fail = 0;
    int own_m [NDESC];
    int idx_m = 0;
    int exp_cnt = 0;
    bit exp_flag = 1'b0;

    function automatic logic [31:0] w0_init(input int i);
        return 32'h100 + 32'(i * BUFB) + ((i == NDESC - 1) ? 32'h2 : 32'h0);
    endfunction

    // Memory model with one-cycle acknowledge; descriptor writes are scored.
    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (mem_addr < 32'(NDESC * 8)) begin
                    sb_chk++;
                    if (exp_q.size() == 0) begin
                        sb_fail++;
                        $display("FAIL R5 unexpected descriptor write actual=%h:%h expected=none",
                                 mem_addr, mem_wdata);
                    end else begin
                        logic [63:0] e;
                        e = exp_q.pop_front();
                        if (e != {mem_addr, mem_wdata}) begin
                            sb_fail++;
                            $display("FAIL R4/R5 descriptor write actual=%h:%h expected=%h:%h",
                                     mem_addr, mem_wdata, e[63:32], e[31:0]);
                        end
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Drive one byte and hold it until taken.
    task automatic put_byte(input logic [7:0] d, input bit s, input bit e);
        bit r;
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
        forever begin
            r = in_ready;
            @(posedge clk);
            @(negedge clk);
            if (r) break;
        end
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    // Predict, drive, then check buffer contents and status for one frame.
    task automatic send_frame(input int len, input logic [7:0] tag);
        int ch_i [8], ch_o [8], ch_l [8];
        int nch = 0, rem = len, off = 0;
        while (rem > 0) begin
            int c;
            if (own_m[idx_m] != 0) begin
                exp_flag = 1'b1;
                if (exp_cnt < CMAX) exp_cnt++;
                break;
            end
            c = (rem > BUFB) ? BUFB : rem;
            exp_q.push_back({32'(idx_m * 8 + 4),
                             32'(c) | ((off == 0) ? 32'h4000 : 32'h0) | ((c == rem) ? 32'h8000 : 32'h0)});
            exp_q.push_back({32'(idx_m * 8), w0_init(idx_m) | 32'h1});
            ch_i[nch] = idx_m; ch_o[nch] = off; ch_l[nch] = c; nch++;
            own_m[idx_m] = 1;
            idx_m = (idx_m == NDESC - 1) ? 0 : idx_m + 1;
            rem -= c; off += c;
        end
        for (int k = 0; k < len; k++) put_byte(tag + 8'(k), k == 0, k == len - 1);
        repeat (20) @(negedge clk);
        for (int n = 0; n < nch; n++) begin
            for (int w = 0; w < (ch_l[n] + 3) / 4; w++) begin
                logic [31:0] ev;
                ev = '0;
                for (int b = 0; b < 4; b++)
                    if (w * 4 + b < ch_l[n]) ev[b*8 +: 8] = tag + 8'(ch_o[n] + w * 4 + b);
                check(mem[(w0_init(ch_i[n]) >> 2) + 32'(w)] == ev, "R3 buffer word",
                      mem[(w0_init(ch_i[n]) >> 2) + 32'(w)], ev);
            end
        end
        check(exp_q.size() == 0, "R4 all descriptor writes seen", exp_q.size(), 0);
        check(int'(res_err_cnt) == exp_cnt, "R7 error count", res_err_cnt, exp_cnt);
        check(irq == exp_flag, "R6 irq level", irq, exp_flag);
        check(nobuf_flag == exp_flag, "R6 status flag", nobuf_flag, exp_flag);
    endtask

    task automatic release_desc(input int i);
        mem[i * 2] = w0_init(i);
        own_m[i] = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk + sb_chk + 1, n_fail + sb_fail);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 256; i++) mem[i] = '0;
        for (int i = 0; i < NDESC; i++) begin
            mem[i * 2] = w0_init(i);
            own_m[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset values
        check(mem_req == 1'b0, "R1 mem_req in reset", mem_req, 0);
        check(in_ready == 1'b0, "R1 in_ready in reset", in_ready, 0);
        check(irq == 1'b0, "R1 irq in reset", irq, 0);
        check(res_err_cnt == '0, "R1 count in reset", res_err_cnt, 0);
        rst_n = 1'b1; rx_en = 1'b1;
        @(negedge clk);
        check(mem_req == 1'b0 && in_ready == 1'b0, "R1 quiet after reset", {mem_req, in_ready}, 0);

        // R2/R3: short frame with a partial last word
        send_frame(10, 8'h10);
        // R4: frame spanning two buffers
        send_frame(200, 8'h40);
        // R4/R5: exactly one full buffer on the wrapping descriptor
        send_frame(128, 8'h90);
        // R6/R7/R8: descriptor 0 still owned after wrap
        send_frame(20, 8'h22);
        repeat (30) @(negedge clk);
        check(irq == 1'b1, "R6 irq held until cleared", irq, 1);
        nobuf_clr = 1'b1;
        @(negedge clk);
        nobuf_clr = 1'b0;
        exp_flag = 1'b0;
        check(irq == 1'b0 && nobuf_flag == 1'b0, "R6 cleared by write-one", {irq, nobuf_flag}, 0);
        check(res_err_cnt == CW'(1), "R7 count kept after clear", res_err_cnt, 1);

        // R8: buffer runs out mid-frame; rest of the frame is discarded
        release_desc(0);
        send_frame(150, 8'h05);
        release_desc(1); release_desc(2); release_desc(3);
        // R8: pointer stayed on descriptor 1
        send_frame(5, 8'hC0);

        // R9: frame held off while receive is off, pointer kept
        rx_en = 1'b0;
        in_valid = 1'b1; in_sof = 1'b1; in_data = 8'h77;
        begin
            bit seen = 1'b0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                if (in_ready || mem_req) seen = 1'b1;
            end
            check(!seen, "R9 no activity while off", seen, 0);
        end
        rx_en = 1'b1;
        send_frame(40, 8'h77);

        // R7: saturation with the ring exhausted
        mem[6] = w0_init(3) | 32'h1;
        own_m[3] = 1;
        for (int f = 0; f < 6; f++) send_frame(3, 8'(f));
        check(res_err_cnt == CW'(CMAX), "R7 saturated", res_err_cnt, CMAX);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk + sb_chk, n_fail + sb_fail);
        $finish;
    end

endmodule